// File: doc/BRIEF.md
# Intra-Slice Channel Shuffle Unit

This unit reorders the channels of one feature-map slice, the part of a layer's channels that a single compute partition owns. The slice size is the total channel count divided by the number of partitions. Data never leaves the slice, so the reorder needs no synchronization with any other partition. The upstream layer streams the slice in channel-major order: every spatial element of channel 0, then every element of channel 1, and so on. The unit captures the whole slice in a local buffer. It then streams the slice back out in shuffled channel order, and a downstream layer can read that stream sequentially.

The slice's channels are split into `NSPLIT` parts of `GRP = CH_SLICE/NSPLIT` channels each. The buffered slice is treated as an array indexed (i, j, k), with i < GRP, j < NSPLIT and k < SPAT. Element (i, j, k) arrives at linear position (i·NSPLIT + j)·SPAT + k. It leaves at linear position (j·GRP + i)·SPAT + k. This is a transpose of the two channel axes. The spatial index is left alone, so each channel's spatial data stays together and keeps its order.

Control is a two-state machine:
- In `SH_FILL` the unit accepts input. It moves to `SH_DRAIN` when the final element of the slice is accepted.
- In `SH_DRAIN` the unit presents output. It returns to `SH_FILL` when the final shuffled element is taken.
- A synchronous reset forces `SH_FILL` and clears both address counters.
- A parameter set with `CH_SLICE` that is not a multiple of `NSPLIT` is rejected at elaboration.

Top module: `chsh_unit`

## Requirements
- R1: After synchronous reset, `in_ready` is 1 and `out_valid` is 0.
- R2: No output is presented (`out_valid` = 0) until all `CH_SLICE·SPAT` elements of a slice have been accepted.
- R3: From the cycle after the final input element is accepted until the slice is fully drained, `in_ready` is 0, and input presented in that time has no effect on the output data.
- R4: Output position p = (j·GRP + i)·SPAT + k carries the input element that arrived at position (i·NSPLIT + j)·SPAT + k.
- R5: Every run of SPAT consecutive outputs, starting at a multiple of SPAT, is one input channel's spatial data in its arrival order.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` hold their values, and no element is skipped.
- R7: `out_last` is 1 on exactly the final (CH_SLICE·SPAT-th) output element of a slice, and 0 on all others.
- R8: In the cycle after the final output is taken, `in_ready` is 1 again, and the next slice is processed with no lost or duplicated element.
- R9: A reset during draining returns the unit to filling, and the next slice is reordered from its first element.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Unit accepts input (filling) |
| in_data | input | DW | Input element |
| in_last | input | 1 | Marks the final element of a slice |
| out_valid | output | 1 | Shuffled element valid |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | DW | Shuffled element |
| out_last | output | 1 | Marks the final shuffled element |

## Verification
Each element of a slice carries its arrival index plus a per-slice offset. A misrouted element therefore shows up as a wrong value at a known output position, and a slice left over from an earlier run shows up as a wrong offset.

The input patterns cover four cases:
- A gap-free fill and a fill with idle cycles separate a correct write counter from one that counts idle cycles.
- Full-rate draining and draining with periodic backpressure separate a read address that advances only on transfers from one that runs free.
- Junk presented on the input during draining, followed by a back-to-back slice, shows whether the input is properly gated.
- A reset in the middle of a drain shows whether both counters restart.

// File: rtl/chsh_pkg.sv
package chsh_pkg;
    typedef enum logic [0:0] {
        SH_FILL  = 1'b0,
        SH_DRAIN = 1'b1
    } sh_state_e;
endpackage

// File: rtl/chsh_wr_ctr.sv
module chsh_wr_ctr #(
    parameter int DEPTH = 32,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [AW-1:0] addr,
    output logic          at_end
);
    logic [AW-1:0] cnt_q;

    assign at_end = (cnt_q == AW'(DEPTH - 1));
    assign addr   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/chsh_rd_gen.sv
module chsh_rd_gen #(
    parameter int GRP    = 4,
    parameter int NSPLIT = 2,
    parameter int SPAT   = 4,
    localparam int DEPTH = GRP * NSPLIT * SPAT,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int IW    = (GRP > 1) ? $clog2(GRP) : 1,
    localparam int JW    = (NSPLIT > 1) ? $clog2(NSPLIT) : 1,
    localparam int KW    = (SPAT > 1) ? $clog2(SPAT) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [AW-1:0] addr,
    output logic          at_end
);
    logic [IW-1:0] i_q;
    logic [JW-1:0] j_q;
    logic [KW-1:0] k_q;
    logic          k_wrap, i_wrap, j_wrap;
    logic [31:0]   lin;

    assign k_wrap = (k_q == KW'(SPAT - 1));
    assign i_wrap = (i_q == IW'(GRP - 1));
    assign j_wrap = (j_q == JW'(NSPLIT - 1));
    assign at_end = k_wrap && i_wrap && j_wrap;

    // spatial index innermost, then group member i, then part j outermost
    assign lin  = (32'(i_q) * 32'(NSPLIT) + 32'(j_q)) * 32'(SPAT) + 32'(k_q);
    assign addr = lin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            i_q <= '0;
            j_q <= '0;
            k_q <= '0;
        end else if (adv) begin
            k_q <= k_wrap ? '0 : k_q + 1'b1;
            if (k_wrap) begin
                i_q <= i_wrap ? '0 : i_q + 1'b1;
                if (i_wrap) begin
                    j_q <= j_wrap ? '0 : j_q + 1'b1;
                end
            end
        end
    end

    // R4: the generated read address always lands inside the slice buffer
    a_r4_rd_in_range: assert property (@(posedge clk) disable iff (rst)
        lin < 32'(DEPTH));
endmodule

// File: rtl/chsh_buf.sv
module chsh_buf #(
    parameter int DW    = 8,
    parameter int DEPTH = 32,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/chsh_unit.sv
module chsh_unit
    import chsh_pkg::*;
#(
    parameter int DW       = 8,
    parameter int CH_SLICE = 8,
    parameter int NSPLIT   = 2,
    parameter int SPAT     = 4,
    localparam int GRP   = CH_SLICE / NSPLIT,
    localparam int DEPTH = CH_SLICE * SPAT,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    input  logic          in_last,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic          out_last
);
    generate
        if (NSPLIT < 1 || CH_SLICE < NSPLIT || (CH_SLICE % NSPLIT) != 0) begin : g_bad_params
            $error("chsh_unit: CH_SLICE must be a positive multiple of NSPLIT");
        end
    endgenerate

    sh_state_e     state_q, state_d;
    logic          in_fire, out_fire;
    logic [AW-1:0] wr_addr, rd_addr;
    logic          wr_end, rd_end;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;

    chsh_wr_ctr #(.DEPTH(DEPTH)) u_wr (
        .clk    (clk),
        .rst    (rst),
        .adv    (in_fire),
        .addr   (wr_addr),
        .at_end (wr_end)
    );

    chsh_rd_gen #(.GRP(GRP), .NSPLIT(NSPLIT), .SPAT(SPAT)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .adv    (out_fire),
        .addr   (rd_addr),
        .at_end (rd_end)
    );

    chsh_buf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .we    (in_fire),
        .waddr (wr_addr),
        .wdata (in_data),
        .raddr (rd_addr),
        .rdata (out_data)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SH_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_FILL:  if (in_fire && wr_end)   state_d = SH_DRAIN;
            SH_DRAIN: if (out_fire && rd_end)  state_d = SH_FILL;
            default:  state_d = SH_FILL;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            SH_FILL:  in_ready  = 1'b1;
            SH_DRAIN: out_valid = 1'b1;
            default:  in_ready  = 1'b0;
        endcase
    end

    assign out_last = out_valid && rd_end;

    // R2: output only rises right after a full slice has been captured
    a_r2_no_early_out: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_fire && wr_end));

    // R3: input gated in the cycle after the final element lands
    a_r3_gate_after_fill: assert property (@(posedge clk) disable iff (rst)
        (in_fire && wr_end) |=> !in_ready);

    // R3: upstream last flag coincides with the buffer filling up
    a_r3_last_aligned: assert property (@(posedge clk) disable iff (rst)
        (in_fire && wr_end) |-> in_last);

    // R6: a stalled output element is held unchanged
    a_r6_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R8: taking the final output reopens the input next cycle
    a_r8_resume_fill: assert property (@(posedge clk) disable iff (rst)
        (out_fire && out_last) |=> (in_ready && !out_valid));
endmodule

// File: tb/sim_chsh_unit.sv
module sim_chsh_unit;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DW = 8, CH = 8, NS = 2, SP = 4;
    localparam int GRP = CH / NS;
    localparam int DEPTH = CH * SP;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready, out_valid, out_last;
    logic [DW-1:0] out_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    chsh_unit #(.DW(DW), .CH_SLICE(CH), .NSPLIT(NS), .SPAT(SP)) u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_val(input int seed, input int p);
        int j = p / (GRP * SP);
        int i = (p / SP) % GRP;
        int k = p % SP;
        return (seed + (i * NS + j) * SP + k) & 8'hFF;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // send one slice; gaps inserts idle cycles; checks R2 while filling
    task automatic send_slice(input int seed, input bit gaps);
        for (int n = 0; n < DEPTH; n++) begin
            in_valid = 1'b1;
            in_data  = DW'(seed + n);
            in_last  = (n == DEPTH - 1);
            while (!in_ready) @(negedge clk);
            check(out_valid == 1'b0, "R2 no output while filling", int'(out_valid), 0);
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
            if (gaps && (n % 3 == 1)) @(negedge clk);
        end
        check(in_ready == 1'b0, "R3 in_ready low after final input", int'(in_ready), 0);
        check(out_valid == 1'b1, "R2 output present after full slice", int'(out_valid), 1);
    endtask

    // drain count elements; stall inserts backpressure; junk drives input meanwhile
    task automatic recv_slice(input int seed, input bit stall, input bit junk, input int count);
        int p = 0;
        int cyc = 0;
        bit held = 1'b0;
        logic [DW-1:0] hd;
        logic hl;
        int first = 0;
        while (p < count) begin
            if (junk) begin
                in_valid = 1'b1;
                in_data  = 8'hA5;
            end
            if (held) begin
                check(out_data == hd && out_last == hl, "R6 stalled element held",
                      int'(out_data), int'(hd));
            end
            out_ready = !(stall && (cyc % 3 == 0));
            if (junk) check(in_ready == 1'b0, "R3 input gated while draining", int'(in_ready), 0);
            if (out_ready && out_valid) begin
                check(int'(out_data) == exp_val(seed, p), "R4 shuffled element", int'(out_data), exp_val(seed, p));
                check(out_last == (p == DEPTH - 1), "R7 last flag position", int'(out_last), int'(p == DEPTH - 1));
                if (p % SP == 0) first = int'(out_data);
                else check(int'(out_data) == ((first + p % SP) & 8'hFF), "R5 spatial order kept",
                           int'(out_data), (first + p % SP) & 8'hFF);
                p++;
                held = 1'b0;
            end else begin
                held = out_valid;
                hd = out_data;
                hl = out_last;
            end
            cyc++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        in_valid  = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    endtask

    task automatic t_plain();
        send_slice(0, 1'b0);
        recv_slice(0, 1'b0, 1'b0, DEPTH);
        check(in_ready == 1'b1, "R8 input reopens after drain", int'(in_ready), 1);
    endtask

    task automatic t_gaps_stall_junk();
        send_slice(40, 1'b1);
        recv_slice(40, 1'b1, 1'b1, DEPTH);
        check(in_ready == 1'b1, "R8 input reopens after stalled drain", int'(in_ready), 1);
    endtask

    task automatic t_back_to_back();
        send_slice(100, 1'b0);
        recv_slice(100, 1'b0, 1'b0, DEPTH);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R8 back-to-back boundary", int'(in_ready), 1);
        send_slice(170, 1'b0);
        recv_slice(170, 1'b1, 1'b0, DEPTH);
    endtask

    task automatic t_reset_mid_drain();
        send_slice(7, 1'b0);
        recv_slice(7, 1'b0, 1'b0, DEPTH / 2);
        do_reset();
        check(in_ready == 1'b1, "R9 filling after mid-drain reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R9 no output after mid-drain reset", int'(out_valid), 0);
        send_slice(200, 1'b0);
        recv_slice(200, 1'b0, 1'b0, DEPTH);
    endtask

    initial begin
        t_reset();
        t_plain();
        t_gaps_stall_junk();
        t_back_to_back();
        t_reset_mid_drain();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule